// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This block turns single-word read and write requests into the pin sequences that a three-wire serial EEPROM needs. The EEPROM holds 2^ADDR_W words of DATA_W bits (64 x 16 by default). A requester raises `req_valid` for one cycle with a direction, an address and, for a write, the data. The block latches these, raises `busy`, and runs the whole access on `ee_cs`, `ee_sk` and `ee_di`. It samples the device's `ee_do` line through a two-stage synchroniser. When the access ends it pulses `done` for one cycle.

Every pin step lasts one phase of PHASE_CLKS system clocks. A read sends its command and address, then clocks in one data word. It ends with a standby toggle, so chip select is left high. A write is bracketed by a write-enable command and a write-disable command, with a standby toggle after each frame. After the data frame the block polls `ee_do` once per phase, for at most POLL_LIMIT samples, and the write finishes with a cleanup that deselects the device.

Top module: `mw_eeprom_master`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `err` and `rdata` are all 0. `ee_sk` is 0 whenever `busy` is 0.
- R2: A read sends, MSB first, the opcode 3'b110 followed by the ADDR_W-bit address. It then takes DATA_W bits MSB first, one per SK pulse, sampling `ee_do` at the end of each SK-high phase. `rdata` receives the word stored at that address.
- R3: The sequence steps of a read are 2 setup phases, 3 phases per command bit, 2 phases per data bit and 4 standby phases. With the defaults this is 65 phases. `busy` is 1 for exactly 65*PHASE_CLKS cycles after the acceptance edge.
- R4: A write sends the following frames, MSB first: write-enable {5'b10011, ADDR_W-2 zeros}, then {3'b101, address, data}, then write-disable {5'b10000, ADDR_W-2 zeros}. Chip select drops after each frame. The device stores the data and is left write-disabled.
- R5: A write takes 146 + n phases with the defaults, where n is the number of completion polls made. n is the index of the first sample that sees `ee_do` high, counted from 1, capped at POLL_LIMIT.
- R6: If none of the POLL_LIMIT samples sees `ee_do` high, `err` rises in the same cycle as `done` and the rest of the write sequence still runs. In every other case `err` is 0 at `done`. Accepting a new request clears `err`.
- R7: A request is accepted only when `busy` is 0, and acceptance raises `busy` on the next cycle. Requests raised while busy have no effect on the pins or on the stored words.
- R8: `rdata` changes only in the cycle where a read raises `done`. A write leaves `rdata` unchanged.
- R9: `ee_di` never changes on the edge where `ee_sk` rises.
- R10: `done` lasts exactly one cycle, and `busy` is 0 while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write word, 0 = read word |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | DATA_W | Last word read, held until the next read ends |
| err | output | 1 | Completion poll timed out on the last write |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device (asynchronous) |

## Verification
The bench builds the block with PHASE_CLKS = 8 and POLL_LIMIT = 6. The short phase keeps a complete write near 1,200 cycles, and is still long enough that the model's data changes on `ee_do` pass the synchroniser before each sample. The small poll bound makes three cases short to run: completion on the first sample, completion on the last allowed sample, and a full timeout. The cycle-exact busy window that the model predicts for each case separates them.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;

    // Command opcodes, sent MSB first; the leading 1 acts as the start bit
    localparam logic [2:0] OP_READ  = 3'b110;
    localparam logic [2:0] OP_WRITE = 3'b101;
    localparam logic [4:0] OP_WEN   = 5'b10011;
    localparam logic [4:0] OP_WDIS  = 5'b10000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD,       // read command or write-enable frame
        ST_SHIN,      // read data capture
        ST_STBY_RD,   // standby closing a read
        ST_STBY_EN,   // standby after write-enable
        ST_WFRAME,    // write opcode, address, data
        ST_STBY_WR,   // standby that starts programming
        ST_POLL,      // wait for ready on ee_do
        ST_STBY_REC,  // recovery standby
        ST_DIS,       // write-disable frame
        ST_CLEAN      // deselect and final clock pulse
    } mw_state_e;

endpackage

// File: rtl/mw_phase_timer.sv
`timescale 1ns/1ps
module mw_phase_timer #(
    parameter int PHASE_CLKS = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (PHASE_CLKS > 2) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = !clear && (cnt_q == LAST);
endmodule

// File: rtl/mw_sync.sv
`timescale 1ns/1ps
module mw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_d, ff_q;

    generate
        if (STAGES == 1) begin : g_one
            assign ff_d = din;
        end else begin : g_chain
            assign ff_d = {ff_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/mw_eeprom_master.sv
`timescale 1ns/1ps
module mw_eeprom_master
    import mw_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int PHASE_CLKS = 6250,
    parameter int POLL_LIMIT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int CMD_W   = 3 + ADDR_W;
    localparam int BIT_CW  = $clog2(FRAME_W + 1);
    localparam int POLL_CW = $clog2(POLL_LIMIT + 1);
    localparam logic [BIT_CW-1:0]  CMD_BITS   = BIT_CW'(CMD_W);
    localparam logic [BIT_CW-1:0]  FRAME_BITS = BIT_CW'(FRAME_W);
    localparam logic [BIT_CW-1:0]  WORD_BITS  = BIT_CW'(DATA_W);
    localparam logic [POLL_CW-1:0] POLL_LAST  = POLL_CW'(POLL_LIMIT - 1);

    typedef struct packed {
        mw_state_e         st;
        logic [1:0]        sub;
        logic [BIT_CW-1:0] bits;
        logic [FRAME_W-1:0] sh;
        logic [DATA_W-1:0] rx;
        logic [POLL_CW-1:0] polls;
        logic              tout;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              busy;
        logic              done;
        logic              err;
        logic              cs;
        logic              sk;
        logic              di;
    } regs_t;

    regs_t d, q;
    logic  tick;
    logic  do_s;

    logic [FRAME_W-1:0] f_read, f_wen, f_write, f_wdis;

    mw_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!q.busy),
        .tick  (tick)
    );

    mw_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ee_do),
        .dout  (do_s)
    );

    always_comb begin
        f_read  = {OP_READ, q.addr, {DATA_W{1'b0}}};
        f_wen   = {OP_WEN, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
        f_write = {OP_WRITE, q.addr, q.wdata};
        f_wdis  = {OP_WDIS, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_SETUP;
                    d.sub   = 2'd0;
                    d.busy  = 1'b1;
                    d.we    = req_write;
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.err   = 1'b0;
                    d.tout  = 1'b0;
                    d.polls = '0;
                    d.sk    = 1'b0;
                    d.di    = 1'b0;
                end
            end
            ST_SETUP: if (tick) begin
                if (q.sub == 2'd0) begin
                    d.sub = 2'd1;
                    d.cs  = 1'b1;
                end else begin
                    d.st   = ST_CMD;
                    d.sub  = 2'd0;
                    d.sh   = q.we ? f_wen : f_read;
                    d.bits = CMD_BITS;
                    d.di   = d.sh[FRAME_W-1];
                end
            end
            ST_CMD, ST_WFRAME, ST_DIS: if (tick) begin
                case (q.sub)
                    2'd0: begin
                        d.sub = 2'd1;
                        d.sk  = 1'b1;
                    end
                    2'd1: begin
                        d.sub  = 2'd2;
                        d.sk   = 1'b0;
                        d.sh   = q.sh << 1;
                        d.bits = q.bits - 1'b1;
                        if (q.bits == BIT_CW'(1)) d.di = 1'b0;
                    end
                    default: begin
                        if (q.bits != '0) begin
                            d.sub = 2'd0;
                            d.di  = q.sh[FRAME_W-1];
                        end else if (q.st == ST_CMD && !q.we) begin
                            d.st   = ST_SHIN;
                            d.sub  = 2'd0;
                            d.bits = WORD_BITS;
                            d.sk   = 1'b1;
                        end else if (q.st == ST_DIS) begin
                            d.st  = ST_CLEAN;
                            d.sub = 2'd0;
                            d.cs  = 1'b0;
                            d.di  = 1'b0;
                        end else begin
                            d.st  = (q.st == ST_CMD) ? ST_STBY_EN : ST_STBY_WR;
                            d.sub = 2'd0;
                            d.cs  = 1'b0;
                            d.sk  = 1'b0;
                        end
                    end
                endcase
            end
            ST_SHIN: if (tick) begin
                if (q.sub == 2'd0) begin
                    d.rx   = {q.rx[DATA_W-2:0], do_s};
                    d.sub  = 2'd1;
                    d.sk   = 1'b0;
                    d.bits = q.bits - 1'b1;
                end else if (q.bits == '0) begin
                    d.st  = ST_STBY_RD;
                    d.sub = 2'd0;
                    d.cs  = 1'b0;
                    d.sk  = 1'b0;
                end else begin
                    d.sub = 2'd0;
                    d.sk  = 1'b1;
                end
            end
            ST_STBY_RD, ST_STBY_EN, ST_STBY_WR, ST_STBY_REC: if (tick) begin
                case (q.sub)
                    2'd0: begin d.sub = 2'd1; d.sk = 1'b1; end
                    2'd1: begin d.sub = 2'd2; d.cs = 1'b1; end
                    2'd2: begin d.sub = 2'd3; d.sk = 1'b0; end
                    default: begin
                        d.sub = 2'd0;
                        case (q.st)
                            ST_STBY_RD: begin
                                d.st    = ST_IDLE;
                                d.busy  = 1'b0;
                                d.done  = 1'b1;
                                d.rdata = q.rx;
                            end
                            ST_STBY_EN: begin
                                d.st   = ST_WFRAME;
                                d.sh   = f_write;
                                d.bits = FRAME_BITS;
                                d.di   = f_write[FRAME_W-1];
                            end
                            ST_STBY_WR: begin
                                d.st    = ST_POLL;
                                d.polls = '0;
                            end
                            default: begin
                                d.st   = ST_DIS;
                                d.sh   = f_wdis;
                                d.bits = CMD_BITS;
                                d.di   = f_wdis[FRAME_W-1];
                            end
                        endcase
                    end
                endcase
            end
            ST_POLL: if (tick) begin
                if (do_s || q.polls == POLL_LAST) begin
                    d.tout = !do_s;
                    d.st   = ST_STBY_REC;
                    d.sub  = 2'd0;
                    d.cs   = 1'b0;
                    d.sk   = 1'b0;
                end else begin
                    d.polls = q.polls + 1'b1;
                end
            end
            ST_CLEAN: if (tick) begin
                case (q.sub)
                    2'd0: begin d.sub = 2'd1; d.sk = 1'b1; end
                    2'd1: begin d.sub = 2'd2; d.sk = 1'b0; end
                    default: begin
                        d.sub  = 2'd0;
                        d.st   = ST_IDLE;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        d.err  = q.tout;
                    end
                endcase
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy  = q.busy;
    assign done  = q.done;
    assign rdata = q.rdata;
    assign err   = q.err;
    assign ee_cs = q.cs;
    assign ee_sk = q.sk;
    assign ee_di = q.di;
endmodule

// File: rtl/mw_eeprom_master_chk.sv
`timescale 1ns/1ps
module mw_eeprom_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rdata,
    input logic              err,
    input logic              ee_sk,
    input logic              ee_di
);
    p_sk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ee_sk);

    p_err_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);

    p_di_at_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk) |-> $stable(ee_di));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind mw_eeprom_master mw_eeprom_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .err       (err),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di)
);

// File: tb/mw_eeprom_master_tb.sv
`timescale 1ns/1ps
module mw_eeprom_master_tb;
    localparam int P     = 8;
    localparam int PL    = 6;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int WORDS = 1 << AW;
    localparam longint NEVER = 64'd1 << 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, done, err, ee_cs, ee_sk, ee_di;
    logic [DW-1:0] rdata;
    logic          ee_do = 1'b0;

    always #4 clk = ~clk;

    mw_eeprom_master #(
        .ADDR_W(AW), .DATA_W(DW), .PHASE_CLKS(P), .POLL_LIMIT(PL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .err(err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do)
    );

    int     vectors = 0;
    int     miscompares = 0;
    longint cyc = 0;
    bit     finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural EEPROM ----------------
    logic [DW-1:0] mem     [WORDS];
    logic [DW-1:0] exp_mem [WORDS];
    logic [31:0]   sh;
    int            nbits = 0;
    bit            wen = 0;
    bit            rd_mode = 0;
    int            rd_k = 0;
    logic [AW-1:0] rd_addr = '0;
    longint        ready_at = NEVER;
    bit            prev_cs = 0, prev_sk = 0, prev_di = 0;
    int            di_glitches = 0;
    bit            rd_bit = 0;

    always @(negedge clk) begin
        if (ee_sk && !prev_sk && ee_di != prev_di) di_glitches++;
        if (prev_cs && !ee_cs) begin
            if (nbits == 9 && sh[8:4] == 5'b10011) wen = 1;
            if (nbits == 9 && sh[8:4] == 5'b10000) wen = 0;
            if (nbits == 25 && sh[24:22] == 3'b101 && wen) mem[sh[21:16]] = sh[15:0];
            nbits = 0;
            rd_mode = 0;
        end else if (ee_cs && ee_sk && !prev_sk) begin
            if (rd_mode) begin
                rd_bit = (rd_k < DW) ? mem[rd_addr][DW-1-rd_k] : 1'b0;
                rd_k++;
            end else if (nbits != 0 || ee_di) begin
                sh = {sh[30:0], ee_di};
                nbits++;
                if (nbits == 9 && sh[8:6] == 3'b110) begin
                    rd_mode = 1;
                    rd_k = 0;
                    rd_addr = sh[5:0];
                    rd_bit = 0;
                end
            end
        end
        ee_do <= rd_mode ? rd_bit : (cyc >= ready_at);
        prev_cs = ee_cs;
        prev_sk = ee_sk;
        prev_di = ee_di;
    end

    // ---------------- reference-timed access ----------------
    // j0: index of the poll step during which the device reports ready
    task automatic run_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input int j0, input bit poke, input string rq);
        int     steps;
        int     polls;
        bit     exp_err;
        longint a0;
        logic [DW-1:0] exp_rd;
        logic [DW-1:0] old_rd;
        logic [AW-1:0] poke_a;
        bit     cyc_ok;
        int     bad_cycles;
        old_rd  = rdata;
        polls   = (j0 + 1 < PL) ? j0 + 1 : PL;
        exp_err = (j0 >= PL);
        steps   = we ? (146 + polls) : 65;
        exp_rd  = we ? old_rd : exp_mem[a];
        poke_a  = a ^ 6'h15;
        bad_cycles = 0;
        @(negedge clk);
        req_valid = 1; req_write = we; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        a0 = cyc;
        ready_at = we ? (a0 + longint'((113 + j0) * P - P / 2)) : NEVER;
        chk(err == 1'b0, "R6 err cleared on accept", err, 0);
        for (int i = 0; i < steps * P; i++) begin
            if (i > 0) @(negedge clk);
            cyc_ok = (busy === 1'b1) && (done === 1'b0);
            if (!cyc_ok) bad_cycles++;
            if (poke && i == 40) begin
                req_valid = 1; req_write = 1; req_addr = poke_a; req_wdata = 16'hDEAD;
            end
            if (poke && i == 41) req_valid = 0;
        end
        chk(bad_cycles == 0, we ? "R5 busy window of write" : "R3 busy window of read",
            bad_cycles, 0);
        @(negedge clk);
        chk({busy, done} == 2'b01, "R10 done pulse at end, busy low", {busy, done}, 2'b01);
        chk(err == exp_err, "R6 err at done", err, exp_err);
        if (we) chk(rdata == old_rd, "R8 rdata kept over write", rdata, old_rd);
        else    chk(rdata == exp_rd, "R2 read data", rdata, exp_rd);
        @(negedge clk);
        chk(done == 1'b0, "R10 done lasts one cycle", done, 0);
        if (we) begin
            exp_mem[a] = wd;
            chk(mem[a] == wd, "R4 device word written", mem[a], wd);
            chk(wen == 0, "R4 device left write-disabled", wen, 0);
        end
        if (poke) chk(mem[poke_a] == exp_mem[poke_a], "R7 request while busy ignored",
                      mem[poke_a], exp_mem[poke_a]);
        ready_at = NEVER;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R7 no extra access started", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i]     = DW'(i * 16'h0101) ^ 16'hA5C3;
            exp_mem[i] = mem[i];
        end
        repeat (5) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done, err} == 6'b0, "R1 pins and flags in reset",
            {ee_cs, ee_sk, ee_di, busy, done, err}, 0);
        chk(rdata == '0, "R1 rdata in reset", rdata, 0);
        rst_n = 1;
        @(negedge clk);
        chk({ee_cs, ee_sk, busy} == 3'b0, "R1 idle after reset", {ee_cs, ee_sk, busy}, 0);

        run_op(0, 6'd5,  '0,       0,      0, "R2");
        run_op(0, 6'd63, '0,       0,      0, "R2");
        run_op(1, 6'd0,  16'h1234, 2,      0, "R4");
        run_op(0, 6'd0,  '0,       0,      0, "R2");
        run_op(1, 6'd63, 16'hFFFF, 0,      0, "R5");
        run_op(1, 6'd33, 16'h0F0F, PL - 1, 0, "R5");
        run_op(1, 6'd17, 16'h8001, PL + 3, 0, "R6");
        run_op(0, 6'd10, '0,       0,      1, "R7");
        run_op(0, 6'd17, '0,       0,      0, "R2");
        run_op(0, 6'd63, '0,       0,      0, "R2");
        chk(di_glitches == 0, "R9 DI stable at SK rise", di_glitches, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: run did not finish actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule